// File: doc/BRIEF.md
# Virtualized Interrupt Routing Controller

This block decides where each interrupt or exception on a core goes. The core runs at one of three privilege levels: guest user, guest supervisor or hypervisor. Every external source has a routing bit that the hypervisor sets. The bit sends that source either into hypervisor mode or straight to the guest. Some events always trap to the hypervisor whatever the routing says: a guest touching a hypervisor-owned resource, and a system call carrying the special operand. An ordinary system call goes to the guest. A doorbell sent by the hypervisor to this core's partition waits until the guest enables doorbells.

Events are latched as pending and taken one per cycle in a fixed priority. Interrupts are taken only while the core is in a guest level. Anything that arrives during hypervisor execution waits until the return to the guest. Taking an event into the hypervisor saves the previous level in a hypervisor save slot. Taking an event into the guest saves it in a separate guest save slot. Each of the two return operations restores its own slot. The block drives a take strobe with the target and a vector number, the current level, and a strobe for each accepted return.

Top module: `virq_router`

## Requirements
- R1: After synchronous reset, priv_level is hypervisor (2'b10), take and ret_done are 0, and no event is pending. The two save slots hold guest supervisor for the hypervisor slot and guest user for the guest slot.
- R2: A request on external source i whose route_guest bit is 0 is latched on the next edge. While the core is at a guest level, the following edge asserts take for one cycle with take_to_hyp=1 and take_vec=i, and moves priv_level to 2'b10. This happens whatever guest_ie is.
- R3: A source whose route_guest bit is 1 is taken only while guest_ie=1 and the core is at a guest level, and otherwise stays pending. When taken, it gives take_to_hyp=0 and take_vec=i, and moves priv_level to guest supervisor (2'b01).
- R4: Nothing is taken while priv_level is 2'b10. A guest-routed interrupt that arrives then stays pending and is taken on the edge after the return to a guest level.
- R5: A priv_fault pulse at a guest level always traps to the hypervisor with take_vec=NSRC, regardless of route_guest. A priv_fault or sc_req presented while at the hypervisor level is ignored and is never taken later.
- R6: sc_req with sc_hyp=1 traps to the hypervisor with take_vec=NSRC+1. sc_req with sc_hyp=0 is delivered to guest supervisor with take_vec=NSRC+2 and ignores guest_ie.
- R7: A db_send whose db_pid equals cur_pid makes a doorbell pending; a db_send with any other ID is dropped. A pending doorbell is taken only while db_enable=1, delivered to guest supervisor with take_vec=NSRC+3.
- R8: When several events are pending, they are taken in this order: priv_fault, hypervisor system call, guest system call, hypervisor-routed sources, guest-routed sources, doorbell.
- R9: Each take saves the level it left, in the hypervisor slot for a trap and in the guest slot for a guest delivery. rfi_hyp at level 2'b10 restores the hypervisor slot. rfi_guest at level 2'b01 restores the guest slot. Neither kind of take overwrites the other slot.
- R10: An accepted return asserts ret_done for one cycle on the next edge, and no event is taken on that edge. A return requested at a level it does not match is ignored.
- R11: At most one event is taken per edge. Among sources of the same routing class, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC | One-cycle request per external source |
| route_guest | input | NSRC | Per-source routing: 1 to guest, 0 to hypervisor |
| guest_ie | input | 1 | Guest interrupt enable |
| priv_fault | input | 1 | Guest access to a hypervisor-owned resource |
| sc_req | input | 1 | System call issued |
| sc_hyp | input | 1 | System call carries the hypervisor operand |
| db_send | input | 1 | Doorbell send from the hypervisor |
| db_pid | input | PID_W | Target partition of the doorbell |
| cur_pid | input | PID_W | Partition running on this core |
| db_enable | input | 1 | Guest doorbell enable |
| rfi_hyp | input | 1 | Return from hypervisor |
| rfi_guest | input | 1 | Return from guest interrupt |
| take | output | 1 | One-cycle strobe: an event was taken |
| take_to_hyp | output | 1 | Taken event entered the hypervisor |
| take_vec | output | VEC_W | Vector number of the taken event |
| priv_level | output | 2 | Current level: 00 guest user, 01 guest supervisor, 10 hypervisor |
| ret_done | output | 1 | One-cycle strobe: a return was accepted |

## Verification
The properties assume that every request input is a synchronous pulse, and that rfi_hyp and rfi_guest are never raised in the same cycle. They also assume that a return is issued only after the take it answers, so the saved levels are real entry points. The stimulus drives all inputs on the falling edge and holds each request for one cycle. It issues each return one cycle after sampling the take it ends, and starts every scenario from guest user with nothing pending.

// File: rtl/virq_pkg.sv
package virq_pkg;
  typedef enum logic [1:0] {
    LVL_GU = 2'b00,
    LVL_GS = 2'b01,
    LVL_HV = 2'b10
  } lvl_e;
endpackage

// File: rtl/virq_pending.sv
// Pending latches: set by requests, cleared when the arbiter takes them.
module virq_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_guest,
  input  logic [NSRC-1:0] irq_req,
  input  logic            flt_req,
  input  logic            hsc_req,
  input  logic            gsc_req,
  input  logic            db_hit,
  input  logic [NSRC-1:0] clr_irq,
  input  logic            clr_flt,
  input  logic            clr_hsc,
  input  logic            clr_gsc,
  input  logic            clr_db,
  output logic [NSRC-1:0] pend_irq,
  output logic            pend_flt,
  output logic            pend_hsc,
  output logic            pend_gsc,
  output logic            pend_db
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) pend_irq[g] <= 1'b0;
      else     pend_irq[g] <= irq_req[g] | (pend_irq[g] & ~clr_irq[g]);
    end
  end

  // synchronous exceptions only exist while a guest is running
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_flt <= 1'b0;
      pend_hsc <= 1'b0;
      pend_gsc <= 1'b0;
      pend_db  <= 1'b0;
    end else begin
      pend_flt <= (in_guest & flt_req) | (pend_flt & ~clr_flt);
      pend_hsc <= (in_guest & hsc_req) | (pend_hsc & ~clr_hsc);
      pend_gsc <= (in_guest & gsc_req) | (pend_gsc & ~clr_gsc);
      pend_db  <= db_hit | (pend_db & ~clr_db);
    end
  end
endmodule

// File: rtl/virq_arbiter.sv
// Fixed-priority selection of the next event to take.
module virq_arbiter #(
  parameter int NSRC  = 8,
  parameter int VEC_W = 4
) (
  input  logic             in_guest,
  input  logic             guest_ie,
  input  logic             db_enable,
  input  logic [NSRC-1:0]  route_guest,
  input  logic [NSRC-1:0]  pend_irq,
  input  logic             pend_flt,
  input  logic             pend_hsc,
  input  logic             pend_gsc,
  input  logic             pend_db,
  output logic             win_valid,
  output logic             win_hyp,
  output logic [VEC_W-1:0] win_vec,
  output logic [NSRC-1:0]  sel_irq,
  output logic             sel_flt,
  output logic             sel_hsc,
  output logic             sel_gsc,
  output logic             sel_db
);
  localparam logic [VEC_W-1:0] VEC_FLT = VEC_W'(NSRC);
  localparam logic [VEC_W-1:0] VEC_HSC = VEC_W'(NSRC + 1);
  localparam logic [VEC_W-1:0] VEC_GSC = VEC_W'(NSRC + 2);
  localparam logic [VEC_W-1:0] VEC_DB  = VEC_W'(NSRC + 3);

  logic [NSRC-1:0]  hv_irq, gs_irq, hv_one, gs_one;
  logic [VEC_W-1:0] hv_idx, gs_idx;

  assign hv_irq = pend_irq & ~route_guest;
  assign gs_irq = pend_irq & route_guest;
  // isolate lowest set bit
  assign hv_one = hv_irq & (~hv_irq + NSRC'(1));
  assign gs_one = gs_irq & (~gs_irq + NSRC'(1));

  always_comb begin
    hv_idx = '0;
    gs_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (hv_one[i]) hv_idx = VEC_W'(i);
      if (gs_one[i]) gs_idx = VEC_W'(i);
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_hyp   = 1'b0;
    win_vec   = '0;
    sel_irq   = '0;
    sel_flt   = 1'b0;
    sel_hsc   = 1'b0;
    sel_gsc   = 1'b0;
    sel_db    = 1'b0;
    if (in_guest) begin
      if (pend_flt) begin
        win_valid = 1'b1; win_hyp = 1'b1; win_vec = VEC_FLT; sel_flt = 1'b1;
      end else if (pend_hsc) begin
        win_valid = 1'b1; win_hyp = 1'b1; win_vec = VEC_HSC; sel_hsc = 1'b1;
      end else if (pend_gsc) begin
        win_valid = 1'b1; win_vec = VEC_GSC; sel_gsc = 1'b1;
      end else if (|hv_irq) begin
        win_valid = 1'b1; win_hyp = 1'b1; win_vec = hv_idx; sel_irq = hv_one;
      end else if ((|gs_irq) && guest_ie) begin
        win_valid = 1'b1; win_vec = gs_idx; sel_irq = gs_one;
      end else if (pend_db && db_enable) begin
        win_valid = 1'b1; win_vec = VEC_DB; sel_db = 1'b1;
      end
    end
  end
endmodule

// File: rtl/virq_level.sv
// Privilege level with separate hypervisor and guest save slots.
module virq_level
  import virq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take_en,
  input  logic       take_hyp,
  input  logic       rfi_hyp,
  input  logic       rfi_guest,
  output logic [1:0] level_o,
  output logic       in_guest,
  output logic       ret_do
);
  lvl_e level_q, hv_save, gs_save;
  logic ret_hv, ret_gs;

  assign ret_hv   = rfi_hyp && (level_q == LVL_HV);
  assign ret_gs   = !ret_hv && rfi_guest && (level_q == LVL_GS);
  assign ret_do   = ret_hv | ret_gs;
  assign in_guest = (level_q != LVL_HV);
  assign level_o  = level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= LVL_HV;
      hv_save <= LVL_GS;
      gs_save <= LVL_GU;
    end else if (ret_hv) begin
      level_q <= hv_save;
    end else if (ret_gs) begin
      level_q <= gs_save;
    end else if (take_en) begin
      if (take_hyp) begin
        hv_save <= level_q;
        level_q <= LVL_HV;
      end else begin
        gs_save <= level_q;
        level_q <= LVL_GS;
      end
    end
  end
endmodule

// File: rtl/virq_router.sv
module virq_router #(
  parameter int NSRC  = 8,
  parameter int PID_W = 4,
  parameter int VEC_W = $clog2(NSRC + 4)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  route_guest,
  input  logic             guest_ie,
  input  logic             priv_fault,
  input  logic             sc_req,
  input  logic             sc_hyp,
  input  logic             db_send,
  input  logic [PID_W-1:0] db_pid,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             db_enable,
  input  logic             rfi_hyp,
  input  logic             rfi_guest,
  output logic             take,
  output logic             take_to_hyp,
  output logic [VEC_W-1:0] take_vec,
  output logic [1:0]       priv_level,
  output logic             ret_done
);
  logic             in_guest, ret_do, take_en;
  logic [NSRC-1:0]  pend_irq, sel_irq;
  logic             pend_flt, pend_hsc, pend_gsc, pend_db;
  logic             sel_flt, sel_hsc, sel_gsc, sel_db;
  logic             win_valid, win_hyp;
  logic [VEC_W-1:0] win_vec;

  assign take_en = win_valid & ~ret_do;

  virq_pending #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .in_guest (in_guest),
    .irq_req  (irq_req),
    .flt_req  (priv_fault),
    .hsc_req  (sc_req & sc_hyp),
    .gsc_req  (sc_req & ~sc_hyp),
    .db_hit   (db_send && (db_pid == cur_pid)),
    .clr_irq  (sel_irq & {NSRC{take_en}}),
    .clr_flt  (sel_flt & take_en),
    .clr_hsc  (sel_hsc & take_en),
    .clr_gsc  (sel_gsc & take_en),
    .clr_db   (sel_db & take_en),
    .pend_irq (pend_irq),
    .pend_flt (pend_flt),
    .pend_hsc (pend_hsc),
    .pend_gsc (pend_gsc),
    .pend_db  (pend_db)
  );

  virq_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .in_guest    (in_guest),
    .guest_ie    (guest_ie),
    .db_enable   (db_enable),
    .route_guest (route_guest),
    .pend_irq    (pend_irq),
    .pend_flt    (pend_flt),
    .pend_hsc    (pend_hsc),
    .pend_gsc    (pend_gsc),
    .pend_db     (pend_db),
    .win_valid   (win_valid),
    .win_hyp     (win_hyp),
    .win_vec     (win_vec),
    .sel_irq     (sel_irq),
    .sel_flt     (sel_flt),
    .sel_hsc     (sel_hsc),
    .sel_gsc     (sel_gsc),
    .sel_db      (sel_db)
  );

  virq_level u_lvl (
    .clk       (clk),
    .rst       (rst),
    .take_en   (take_en),
    .take_hyp  (win_hyp),
    .rfi_hyp   (rfi_hyp),
    .rfi_guest (rfi_guest),
    .level_o   (priv_level),
    .in_guest  (in_guest),
    .ret_do    (ret_do)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take        <= 1'b0;
      take_to_hyp <= 1'b0;
      take_vec    <= '0;
      ret_done    <= 1'b0;
    end else begin
      take     <= take_en;
      ret_done <= ret_do;
      if (take_en) begin
        take_to_hyp <= win_hyp;
        take_vec    <= win_vec;
      end
    end
  end
endmodule

// File: rtl/virq_router_chk.sv
module virq_router_chk #(
  parameter int NSRC  = 8,
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             guest_ie,
  input logic             take,
  input logic             take_to_hyp,
  input logic [VEC_W-1:0] take_vec,
  input logic [1:0]       priv_level,
  input logic             ret_done
);
  // R1
  legal_level_chk: assert property (@(posedge clk) disable iff (rst)
    priv_level != 2'b11);
  // R2
  hyp_entry_level_chk: assert property (@(posedge clk) disable iff (rst)
    (take && take_to_hyp) |-> (priv_level == 2'b10));
  // R3
  guest_entry_level_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !take_to_hyp) |-> (priv_level == 2'b01));
  // R3
  guest_ie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !take_to_hyp && (take_vec < VEC_W'(NSRC))) |-> $past(guest_ie));
  // R4
  take_from_guest_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> ($past(priv_level) != 2'b10));
  // R5
  fault_to_hyp_chk: assert property (@(posedge clk) disable iff (rst)
    (take && (take_vec == VEC_W'(NSRC))) |-> take_to_hyp);
  // R9
  hyp_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_done && ($past(priv_level) == 2'b10)) |-> (priv_level != 2'b10));
  // R10
  no_take_on_return_chk: assert property (@(posedge clk) disable iff (rst)
    ret_done |-> !take);
endmodule

bind virq_router virq_router_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .guest_ie    (guest_ie),
  .take        (take),
  .take_to_hyp (take_to_hyp),
  .take_vec    (take_vec),
  .priv_level  (priv_level),
  .ret_done    (ret_done)
);

// File: tb/tb_virq_router.sv
module tb_virq_router;
  localparam int NSRC  = 8;
  localparam int PID_W = 4;
  localparam int VEC_W = $clog2(NSRC + 4);
  localparam int GU = 0, GS = 1, HV = 2;
  localparam int V_FLT = NSRC, V_HSC = NSRC + 1, V_GSC = NSRC + 2, V_DB = NSRC + 3;

  // table row: {source[2:0], route_to_guest}
  localparam int NROW = 6;
  localparam logic [3:0] TBL [NROW] = '{
    {3'd0, 1'b0}, {3'd3, 1'b1}, {3'd7, 1'b0},
    {3'd7, 1'b1}, {3'd5, 1'b1}, {3'd2, 1'b0}
  };

  logic clk = 0;
  logic rst = 1;
  logic [NSRC-1:0]  irq_req = '0, route_guest = '0;
  logic             guest_ie = 0, priv_fault = 0, sc_req = 0, sc_hyp = 0;
  logic             db_send = 0, db_enable = 0, rfi_hyp = 0, rfi_guest = 0;
  logic [PID_W-1:0] db_pid = '0, cur_pid = '0;
  logic             take, take_to_hyp, ret_done;
  logic [VEC_W-1:0] take_vec;
  logic [1:0]       priv_level;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  virq_router #(.NSRC(NSRC), .PID_W(PID_W)) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .route_guest(route_guest),
    .guest_ie(guest_ie), .priv_fault(priv_fault), .sc_req(sc_req), .sc_hyp(sc_hyp),
    .db_send(db_send), .db_pid(db_pid), .cur_pid(cur_pid), .db_enable(db_enable),
    .rfi_hyp(rfi_hyp), .rfi_guest(rfi_guest), .take(take), .take_to_hyp(take_to_hyp),
    .take_vec(take_vec), .priv_level(priv_level), .ret_done(ret_done)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic expect_take(input string r, input int hyp, input int vec, input int lvl);
    chk({r, " take"}, int'(take), 1);
    chk({r, " to_hyp"}, int'(take_to_hyp), hyp);
    chk({r, " vec"}, int'(take_vec), vec);
    chk({r, " level"}, int'(priv_level), lvl);
  endtask

  task automatic expect_idle(input string r, input int lvl);
    chk({r, " no take"}, int'(take), 0);
    chk({r, " level"}, int'(priv_level), lvl);
  endtask

  task automatic ret_hyp(input string r, input int lvl);
    rfi_hyp = 1; tick; rfi_hyp = 0;
    chk({r, " ret_done"}, int'(ret_done), 1);
    chk({r, " no take at return"}, int'(take), 0);
    chk({r, " restored level"}, int'(priv_level), lvl);
  endtask

  task automatic ret_guest(input string r, input int lvl);
    rfi_guest = 1; tick; rfi_guest = 0;
    chk({r, " ret_done"}, int'(ret_done), 1);
    chk({r, " no take at return"}, int'(take), 0);
    chk({r, " restored level"}, int'(priv_level), lvl);
  endtask

  task automatic pulse_irq(input logic [NSRC-1:0] m);
    irq_req = m; tick; irq_req = '0; tick;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst = 0;
    tick;
    // R1 reset state
    chk("R1 take", int'(take), 0);
    chk("R1 ret_done", int'(ret_done), 0);
    chk("R1 level", int'(priv_level), HV);
    tick;
    chk("R1 nothing pending", int'(take), 0);
    ret_hyp("R1 hyp slot", GS);
    ret_guest("R1 guest slot", GU);

    // R2 / R3 table walk, each row returns to guest user
    guest_ie = 1;
    cur_pid  = 4'd5;
    for (int k = 0; k < NROW; k++) begin
      int src;
      logic rg;
      src = int'(TBL[k][3:1]);
      rg  = TBL[k][0];
      route_guest = '0;
      route_guest[src] = rg;
      tick;
      pulse_irq(NSRC'(1) << src);
      if (rg) begin
        expect_take("R3 table", 0, src, GS);
        ret_guest("R3 table", GU);
      end else begin
        expect_take("R2 table", 1, src, HV);
        ret_hyp("R2 table", GU);
      end
    end

    // R2 hypervisor-routed ignores guest_ie
    guest_ie = 0; route_guest = '0; tick;
    pulse_irq(8'h02);
    expect_take("R2 ie off", 1, 1, HV);
    ret_hyp("R2 ie off", GU);

    // R3 guest-routed held while guest_ie is 0
    route_guest = 8'h04; tick;
    pulse_irq(8'h04);
    expect_idle("R3 held", GU);
    tick;
    expect_idle("R3 held", GU);
    guest_ie = 1; tick;
    expect_take("R3 released", 0, 2, GS);
    ret_guest("R3 released", GU);

    // R5 fault traps despite guest routing; R4 hold in hypervisor
    route_guest = '1; tick;
    priv_fault = 1; tick; priv_fault = 0; tick;
    expect_take("R5 fault", 1, V_FLT, HV);
    irq_req = 8'h08; priv_fault = 1; sc_req = 1; sc_hyp = 1; tick;
    irq_req = '0; priv_fault = 0; sc_req = 0; sc_hyp = 0; tick;
    expect_idle("R4 held in hyp", HV);
    tick;
    expect_idle("R4 held in hyp", HV);
    ret_hyp("R4 return", GU);
    tick;
    expect_take("R4 delivered", 0, 3, GS);
    ret_guest("R4 delivered", GU);
    tick;
    expect_idle("R5 ignored in hyp", GU);
    tick;
    expect_idle("R5 ignored in hyp", GU);

    // R6 system calls
    route_guest = '0;
    sc_req = 1; sc_hyp = 1; tick; sc_req = 0; sc_hyp = 0; tick;
    expect_take("R6 hyp call", 1, V_HSC, HV);
    ret_hyp("R6 hyp call", GU);
    guest_ie = 0;
    sc_req = 1; tick; sc_req = 0; tick;
    expect_take("R6 guest call", 0, V_GSC, GS);
    ret_guest("R6 guest call", GU);
    guest_ie = 1;

    // R7 doorbells
    db_enable = 1; db_send = 1; db_pid = 4'd3; tick; db_send = 0; tick;
    expect_idle("R7 other pid", GU);
    tick;
    expect_idle("R7 other pid", GU);
    db_enable = 0; db_send = 1; db_pid = 4'd5; tick; db_send = 0; tick;
    expect_idle("R7 disabled", GU);
    tick;
    expect_idle("R7 disabled", GU);
    db_enable = 1; tick;
    expect_take("R7 enabled", 0, V_DB, GS);
    ret_guest("R7 enabled", GU);
    tick;
    expect_idle("R7 dropped pid", GU);

    // R8 priority across classes
    route_guest = 8'h01;
    priv_fault = 1; irq_req = 8'h03; db_send = 1; db_pid = 4'd5; tick;
    priv_fault = 0; irq_req = '0; db_send = 0; tick;
    expect_take("R8 first fault", 1, V_FLT, HV);
    ret_hyp("R8", GU);
    tick;
    expect_take("R8 hyp irq", 1, 1, HV);
    ret_hyp("R8", GU);
    tick;
    expect_take("R8 guest irq", 0, 0, GS);
    ret_guest("R8", GU);
    tick;
    expect_take("R8 doorbell", 0, V_DB, GS);
    ret_guest("R8", GU);
    tick;
    expect_idle("R8 drained", GU);

    // R11 lowest index first
    route_guest = '0; tick;
    pulse_irq(8'h30);
    expect_take("R11 low", 1, 4, HV);
    ret_hyp("R11", GU);
    tick;
    expect_take("R11 next", 1, 5, HV);
    ret_hyp("R11", GU);
    tick;
    expect_idle("R11 drained", GU);

    // R9 independent save slots
    route_guest = 8'h40; tick;
    pulse_irq(8'h40);
    expect_take("R9 guest entry", 0, 6, GS);
    priv_fault = 1; tick; priv_fault = 0; tick;
    expect_take("R9 trap from gs", 1, V_FLT, HV);
    ret_hyp("R9 hyp slot", GS);
    ret_guest("R9 guest slot", GU);

    // R10 returns ignored at wrong level
    rfi_hyp = 1; tick; rfi_hyp = 0;
    chk("R10 ignored hyp ret", int'(ret_done), 0);
    chk("R10 ignored hyp ret level", int'(priv_level), GU);
    rfi_guest = 1; tick; rfi_guest = 0;
    chk("R10 ignored guest ret", int'(ret_done), 0);
    chk("R10 ignored guest ret level", int'(priv_level), GU);

    // R10 return blocks a take in the same cycle
    route_guest = '0;
    sc_req = 1; tick; sc_req = 0; tick;
    expect_take("R10 to gs", 0, V_GSC, GS);
    irq_req = 8'h04; tick; irq_req = '0;
    ret_guest("R10 block", GU);
    tick;
    expect_take("R10 after return", 1, 2, HV);
    ret_hyp("R10", GU);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule